// File: doc/BRIEF.md
# Dual Serial Interface Mode Selector

This block decides which serial protocol a peripheral with shared pins speaks. Out of reset the peripheral answers on I2C. A host that wants SPI instead sends a short burst of pulses on the chip-select pin. The block brings chip-select into the system clock domain and counts its low-to-high transitions. When the configured number of pulses has arrived, it locks into SPI mode. From then on, chip-select only frames SPI transfers. Nothing except reset returns the block to I2C.

The selected mode drives a pair of complementary engine enables and a combinational pin router. The router connects the shared clock and data pins, the SDA pull-down request and the SPI data-out path to whichever slave engine is active. The idle engine sees constant, quiescent inputs. The I2C open-drain pull-down is released whenever SPI mode is locked.

Top module: `ifsel_top`

## Requirements
- R1: While reset is asserted and right after it is released, spi_mode is 0, i2c_en is 1 and spi_en is 0.
- R2: Fewer than LOCK_PULSES (default 3) rising edges of chip-select since reset leave spi_mode at 0.
- R3: The rising edge numbered LOCK_PULSES on the raw chip-select sets spi_mode to 1 exactly SYNC_STAGES+1 clock edges after the raw rise (3 edges by default). It is still 0 one edge earlier.
- R4: Once spi_mode is 1, it stays 1 under any further chip-select activity.
- R5: Only reset clears spi_mode back to 0.
- R6: With spi_mode at 0, the I2C side is connected and the SPI side is held idle:
  - i2c_scl follows pin_clk.
  - i2c_sda_in follows pin_dat.
  - sda_pull_low follows i2c_sda_low_req.
  - spi_sclk and spi_din are 0, spi_cs_n is 1 and pin_dout_oe is 0.
- R7: With spi_mode at 1, the SPI side is connected and the I2C side is held idle:
  - spi_sclk follows pin_clk and spi_din follows pin_dat.
  - pin_dout and pin_dout_oe follow spi_dout and spi_dout_oe.
  - spi_cs_n follows chip-select after SYNC_STAGES clock edges.
  - i2c_scl and i2c_sda_in are 1, and sda_pull_low is 0 whatever i2c_sda_low_req is.
- R8: Only low-to-high transitions of the synchronized chip-select are counted. A chip-select held high through reset release counts as no edge, and a long high level counts once.
- R9: spi_en equals spi_mode and i2c_en is its complement at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_pin | input | 1 | Raw chip-select from the pad, asynchronous |
| pin_clk | input | 1 | Shared serial clock pin (SCL or SCLK) |
| pin_dat | input | 1 | Shared serial data-in pin (SDA or DIN) |
| i2c_sda_low_req | input | 1 | I2C engine request to pull SDA low |
| spi_dout | input | 1 | SPI engine serial output data |
| spi_dout_oe | input | 1 | SPI engine output enable for data out |
| spi_mode | output | 1 | 1 when SPI mode is locked |
| i2c_en | output | 1 | Enable for the I2C slave engine |
| spi_en | output | 1 | Enable for the SPI slave engine |
| i2c_scl | output | 1 | Clock seen by the I2C engine |
| i2c_sda_in | output | 1 | Data seen by the I2C engine |
| sda_pull_low | output | 1 | Open-drain pull-down drive for SDA |
| spi_sclk | output | 1 | Clock seen by the SPI engine |
| spi_din | output | 1 | Data seen by the SPI engine |
| spi_cs_n | output | 1 | Synchronized chip-select seen by the SPI engine |
| pin_dout | output | 1 | Data driven onto the data-out pin |
| pin_dout_oe | output | 1 | Output enable for the data-out pin |

## Verification
The bench uses the default parameters: two synchronizer stages and a lock after three pulses. With these values the whole pulse-count boundary can be walked from a table of zero to five pulses. The lock latency is a fixed three clock edges, so the bench can check it at the exact cycle on both sides. A one-cycle-wide pulse train and a chip-select held high across reset release exercise the edge detector's narrowest and degenerate cases.

// File: rtl/ifsel_pkg.sv
package ifsel_pkg;

    typedef enum logic {
        MODE_I2C = 1'b0,
        MODE_SPI = 1'b1
    } if_mode_e;

    // Inputs the router hands to the SPI engine while it is parked
    localparam logic SPI_IDLE_SCLK = 1'b0;
    localparam logic SPI_IDLE_DIN  = 1'b0;
    localparam logic SPI_IDLE_CSN  = 1'b1;

    // Inputs the router hands to the I2C engine while it is parked (bus idle)
    localparam logic I2C_IDLE_SCL  = 1'b1;
    localparam logic I2C_IDLE_SDA  = 1'b1;

endpackage

// File: rtl/ifsel_sync.sv
module ifsel_sync #(
    parameter int STAGES    = 2,
    parameter bit RST_LEVEL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);

    typedef struct packed {
        logic [STAGES-1:0] chain;
    } sync_st_t;

    sync_st_t st_d, st_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb begin
                st_d       = st_q;
                st_d.chain = d_async;
            end
        end else begin : g_multi
            always_comb begin
                st_d       = st_q;
                st_d.chain = {st_q.chain[STAGES-2:0], d_async};
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.chain <= {STAGES{RST_LEVEL}};
        end else begin
            st_q <= st_d;
        end
    end

    assign q_sync = st_q.chain[STAGES-1];

endmodule

// File: rtl/ifsel_lock.sv
module ifsel_lock
    import ifsel_pkg::*;
#(
    parameter int LOCK_PULSES = 3
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     cs_s,
    output if_mode_e mode,
    output logic     cs_rise
);

    localparam int CNT_W = (LOCK_PULSES > 1) ? $clog2(LOCK_PULSES) : 1;
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(LOCK_PULSES - 1);

    typedef struct packed {
        logic             cs_prev;
        logic [CNT_W-1:0] cnt;
        if_mode_e         mode;
    } lock_st_t;

    lock_st_t st_d, st_q;
    logic     rise;

    always_comb begin
        st_d         = st_q;
        st_d.cs_prev = cs_s;
        rise         = cs_s & ~st_q.cs_prev;
        if (rise && (st_q.mode == MODE_I2C)) begin
            if (st_q.cnt == LAST_IDX) begin
                st_d.mode = MODE_SPI;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cs_prev <= 1'b1;
            st_q.cnt     <= '0;
            st_q.mode    <= MODE_I2C;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode    = st_q.mode;
    assign cs_rise = rise;

endmodule

// File: rtl/ifsel_route.sv
module ifsel_route
    import ifsel_pkg::*;
(
    input  if_mode_e mode,
    input  logic     cs_s,
    input  logic     pin_clk,
    input  logic     pin_dat,
    input  logic     i2c_sda_low_req,
    input  logic     spi_dout,
    input  logic     spi_dout_oe,
    output logic     i2c_scl,
    output logic     i2c_sda_in,
    output logic     sda_pull_low,
    output logic     spi_sclk,
    output logic     spi_din,
    output logic     spi_cs_n,
    output logic     pin_dout,
    output logic     pin_dout_oe
);

    always_comb begin
        if (mode == MODE_SPI) begin
            i2c_scl      = I2C_IDLE_SCL;
            i2c_sda_in   = I2C_IDLE_SDA;
            sda_pull_low = 1'b0;
            spi_sclk     = pin_clk;
            spi_din      = pin_dat;
            spi_cs_n     = cs_s;
            pin_dout     = spi_dout;
            pin_dout_oe  = spi_dout_oe;
        end else begin
            i2c_scl      = pin_clk;
            i2c_sda_in   = pin_dat;
            sda_pull_low = i2c_sda_low_req;
            spi_sclk     = SPI_IDLE_SCLK;
            spi_din      = SPI_IDLE_DIN;
            spi_cs_n     = SPI_IDLE_CSN;
            pin_dout     = 1'b0;
            pin_dout_oe  = 1'b0;
        end
    end

endmodule

// File: rtl/ifsel_top.sv
module ifsel_top
    import ifsel_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int LOCK_PULSES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_pin,
    input  logic pin_clk,
    input  logic pin_dat,
    input  logic i2c_sda_low_req,
    input  logic spi_dout,
    input  logic spi_dout_oe,
    output logic spi_mode,
    output logic i2c_en,
    output logic spi_en,
    output logic i2c_scl,
    output logic i2c_sda_in,
    output logic sda_pull_low,
    output logic spi_sclk,
    output logic spi_din,
    output logic spi_cs_n,
    output logic pin_dout,
    output logic pin_dout_oe
);

    logic     cs_s;
    logic     cs_rise;
    if_mode_e mode;

    ifsel_sync #(
        .STAGES    (SYNC_STAGES),
        .RST_LEVEL (1'b1)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (cs_pin),
        .q_sync  (cs_s)
    );

    ifsel_lock #(
        .LOCK_PULSES (LOCK_PULSES)
    ) u_lock (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_s    (cs_s),
        .mode    (mode),
        .cs_rise (cs_rise)
    );

    ifsel_route u_route (
        .mode            (mode),
        .cs_s            (cs_s),
        .pin_clk         (pin_clk),
        .pin_dat         (pin_dat),
        .i2c_sda_low_req (i2c_sda_low_req),
        .spi_dout        (spi_dout),
        .spi_dout_oe     (spi_dout_oe),
        .i2c_scl         (i2c_scl),
        .i2c_sda_in      (i2c_sda_in),
        .sda_pull_low    (sda_pull_low),
        .spi_sclk        (spi_sclk),
        .spi_din         (spi_din),
        .spi_cs_n        (spi_cs_n),
        .pin_dout        (pin_dout),
        .pin_dout_oe     (pin_dout_oe)
    );

    assign spi_mode = (mode == MODE_SPI);
    assign spi_en   = (mode == MODE_SPI);
    assign i2c_en   = (mode == MODE_I2C);

endmodule

// File: rtl/ifsel_top_chk.sv
module ifsel_top_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_s,
    input logic cs_rise,
    input logic spi_mode,
    input logic i2c_en,
    input logic spi_en,
    input logic i2c_scl,
    input logic i2c_sda_in,
    input logic sda_pull_low,
    input logic spi_cs_n,
    input logic pin_dout_oe
);

    // R1: a cycle spent in reset leaves the block in I2C mode
    assert_reset_i2c_R1: assert property (@(posedge clk)
        !rst_n |=> (!spi_mode && i2c_en && !spi_en));

    // R4: the lock is sticky while out of reset
    assert_lock_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        spi_mode |=> spi_mode);

    // R8: the lock is only ever taken right after a low-to-high synchronized chip-select
    assert_lock_on_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_mode) |-> ($past(cs_s) && $past(cs_rise)));

    // R6: SPI engine sees an idle chip-select and cannot drive the pin in I2C mode
    assert_spi_parked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !spi_mode |-> (spi_cs_n && !pin_dout_oe));

    // R7: I2C side released and idle after lock
    assert_i2c_parked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        spi_mode |-> (!sda_pull_low && i2c_scl && i2c_sda_in));

    // R9: exactly one engine enabled
    assert_one_engine_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({i2c_en, spi_en}) == 1);

endmodule

bind ifsel_top ifsel_top_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cs_s         (cs_s),
    .cs_rise      (cs_rise),
    .spi_mode     (spi_mode),
    .i2c_en       (i2c_en),
    .spi_en       (spi_en),
    .i2c_scl      (i2c_scl),
    .i2c_sda_in   (i2c_sda_in),
    .sda_pull_low (sda_pull_low),
    .spi_cs_n     (spi_cs_n),
    .pin_dout_oe  (pin_dout_oe)
);

// File: tb/sim_ifsel_top.sv
`timescale 1ns/1ps
module sim_ifsel_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_pin = 1'b0;
    logic pin_clk = 1'b0;
    logic pin_dat = 1'b0;
    logic i2c_sda_low_req = 1'b0;
    logic spi_dout = 1'b0;
    logic spi_dout_oe = 1'b0;
    logic spi_mode, i2c_en, spi_en, i2c_scl, i2c_sda_in, sda_pull_low;
    logic spi_sclk, spi_din, spi_cs_n, pin_dout, pin_dout_oe;

    int tests = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    ifsel_top #(.SYNC_STAGES(2), .LOCK_PULSES(3)) u0 (
        .clk(clk), .rst_n(rst_n), .cs_pin(cs_pin), .pin_clk(pin_clk),
        .pin_dat(pin_dat), .i2c_sda_low_req(i2c_sda_low_req),
        .spi_dout(spi_dout), .spi_dout_oe(spi_dout_oe),
        .spi_mode(spi_mode), .i2c_en(i2c_en), .spi_en(spi_en),
        .i2c_scl(i2c_scl), .i2c_sda_in(i2c_sda_in), .sda_pull_low(sda_pull_low),
        .spi_sclk(spi_sclk), .spi_din(spi_din), .spi_cs_n(spi_cs_n),
        .pin_dout(pin_dout), .pin_dout_oe(pin_dout_oe)
    );

    // {pulses[3:0], high cycles[3:0], low cycles[3:0], expected spi_mode}
    localparam logic [12:0] VEC [8] = '{
        {4'd0, 4'd2, 4'd2, 1'b0},
        {4'd1, 4'd2, 4'd2, 1'b0},
        {4'd2, 4'd2, 4'd2, 1'b0},
        {4'd2, 4'd9, 4'd3, 1'b0},
        {4'd3, 4'd2, 4'd2, 1'b1},
        {4'd3, 4'd1, 4'd1, 1'b1},
        {4'd4, 4'd3, 4'd2, 1'b1},
        {4'd5, 4'd1, 4'd4, 1'b1}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic cs_level);
        cs_pin = cs_level;
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic pulse(input int hi, input int lo);
        cs_pin = 1'b1;
        repeat (hi) @(negedge clk);
        cs_pin = 1'b0;
        repeat (lo) @(negedge clk);
    endtask

    initial begin : watchdog
        #(200000 * 5);
        tests++;
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        chk("R1 spi_mode in reset", spi_mode, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 spi_mode after reset", spi_mode, 0);
        chk("R1 i2c_en after reset", i2c_en, 1);
        chk("R1 spi_en after reset", spi_en, 0);

        for (int i = 0; i < 8; i++) begin
            do_reset(1'b0);
            repeat (2) @(negedge clk);
            for (int p = 0; p < int'(VEC[i][12:9]); p++)
                pulse(int'(VEC[i][8:5]), int'(VEC[i][4:1]));
            repeat (4) @(negedge clk);
            chk(VEC[i][0] ? "R3 table lock" : "R2 table no lock", spi_mode, VEC[i][0]);
            chk("R9 enables", {spi_en, i2c_en}, VEC[i][0] ? 2'b10 : 2'b01);
        end

        // R6: routing in I2C mode, two pin patterns
        do_reset(1'b0);
        @(negedge clk);
        pin_clk = 1'b1; pin_dat = 1'b0; i2c_sda_low_req = 1'b1;
        spi_dout = 1'b1; spi_dout_oe = 1'b1;
        #1;
        chk("R6 i2c route a", {i2c_scl, i2c_sda_in, sda_pull_low}, 3'b101);
        chk("R6 spi parked a", {spi_sclk, spi_din, spi_cs_n, pin_dout_oe}, 4'b0010);
        pin_clk = 1'b0; pin_dat = 1'b1; i2c_sda_low_req = 1'b0;
        #1;
        chk("R6 i2c route b", {i2c_scl, i2c_sda_in, sda_pull_low}, 3'b010);
        chk("R6 spi parked b", {spi_sclk, spi_din, spi_cs_n, pin_dout_oe}, 4'b0010);

        // R3: exact latency of the third rise
        pulse(2, 2);
        pulse(2, 2);
        cs_pin = 1'b1;
        repeat (2) @(negedge clk);
        chk("R3 not yet locked one edge early", spi_mode, 0);
        @(negedge clk);
        chk("R3 locked on third edge", spi_mode, 1);

        // R7: routing in SPI mode
        pin_clk = 1'b1; pin_dat = 1'b1; i2c_sda_low_req = 1'b1;
        spi_dout = 1'b1; spi_dout_oe = 1'b1;
        #1;
        chk("R7 i2c parked", {i2c_scl, i2c_sda_in, sda_pull_low}, 3'b110);
        chk("R7 spi route a", {spi_sclk, spi_din, pin_dout, pin_dout_oe}, 4'b1111);
        chk("R7 cs high", spi_cs_n, 1);
        pin_clk = 1'b0; pin_dat = 1'b0; spi_dout = 1'b0; spi_dout_oe = 1'b0;
        cs_pin = 1'b0;
        @(negedge clk);
        chk("R7 cs delayed", spi_cs_n, 1);
        @(negedge clk);
        chk("R7 cs low after sync", spi_cs_n, 0);
        chk("R7 spi route b", {spi_sclk, spi_din, pin_dout, pin_dout_oe}, 4'b0000);

        // R4: further framing never unlocks
        for (int k = 0; k < 10; k++) begin
            pulse(1 + (k % 3), 2);
            chk("R4 sticky", spi_mode, 1);
        end

        // R5: only reset clears the lock
        do_reset(1'b0);
        @(negedge clk);
        chk("R5 reset clears lock", spi_mode, 0);

        // R8: chip-select high across reset release is not an edge
        do_reset(1'b1);
        repeat (3) @(negedge clk);
        cs_pin = 1'b0;
        repeat (3) @(negedge clk);
        pulse(2, 2);
        pulse(2, 2);
        repeat (4) @(negedge clk);
        chk("R8 high at reset not counted", spi_mode, 0);
        pulse(30, 2);
        repeat (4) @(negedge clk);
        chk("R8 long high counts once", spi_mode, 1);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule